// File: doc/BRIEF.md
# Thermal Throttle Level Controller

This block turns a temperature reading into one of four throttle states, T0 (none) to T3 (heaviest). Software programs three 9-bit temperature thresholds into a single 32-bit configuration word, then turns throttling on. While throttling is on and the sensor reports valid data, the reading is placed in one of four bands set by the thresholds. The band number is the 2-bit state.

A force-enable bit makes one power-management sync code push the state up to at least T2. A lock bit freezes the whole word until the next reset. The thresholds are guarded: they only take new values while throttling is off, both before the write and in the written word. Software therefore has to clear the enable, change the thresholds, and then enable again.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset the configuration word reads 0 and the throttle state is T0.
- R2: The word layout is: first threshold in bits 8:0, second threshold in bits 18:10, third threshold in bits 28:20, enable in bit 29, force-enable in bit 30, lock in bit 31. Bits 9 and 19 always read 0. A read returns the current contents.
- R3: Once the lock bit has been written as 1, every write is ignored until reset. The lock cannot be cleared by a write.
- R4: The state is T0 (code 0) when the enable is 0, or the sensor-valid input is 0, or the reading is less than or equal to the first threshold. This holds unless R6 applies.
- R5: With the enable and sensor-valid both 1, the state is T1 (code 1) for readings above the first threshold and up to the second. It is T2 (code 2) for readings above the second and up to the third. It is T3 (code 3) for readings above the third.
- R6: When the force-enable is 1 and the sync-state input equals FORCE_CODE (13), the state is at least T2, even with the enable at 0. No other sync code forces the state.
- R7: A write updates the thresholds only if the stored enable is 0 and bit 29 of the written data is 0. Otherwise the thresholds stay as they were, but the enable, force-enable and lock bits still take the written values.
- R8: The state output is registered. It reflects the inputs and the configuration one clock edge after they change.
- R9: A single write can set the lock, force-enable and enable bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Data to write |
| rd_data | output | 32 | Current configuration word |
| temp | input | 9 | Temperature reading |
| sense_en | input | 1 | Sensor reading valid |
| pm_state | input | SYNC_W | Power-management sync state code |
| throttle | output | 2 | Throttle state, 0 = T0 to 3 = T3 |

## Verification
The bench uses the default parameters: a 4-bit sync code with FORCE_CODE at 13. This lets the bench compare the forcing code against its neighbour, code 12. The thresholds are set to 100, 200 and 300, so each band edge can be tested on both sides, along with the full-scale reading of 511. A second set of thresholds (10, 20, 30) is loaded together with the lock, to show that the lock sequence works and that the locked contents survive a later write. A final reset confirms that the lock clears.

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
  parameter int TW         = 9,
  parameter int SYNC_W     = 4,
  parameter int FORCE_CODE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [TW-1:0]     temp,
  input  logic              sense_en,
  input  logic [SYNC_W-1:0] pm_state,
  output logic [1:0]        throttle
);
  localparam int L1_LSB = 10;
  localparam int L2_LSB = 20;

  logic          lock_q, force_q, en_q;
  logic [TW-1:0] lvl0_q, lvl1_q, lvl2_q;
  logic [1:0]    band, next_state;
  logic          forced;

  wire accept  = wr_en && !lock_q;
  wire lvl_ok  = accept && !en_q && !wr_data[29];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      force_q <= 1'b0;
      en_q    <= 1'b0;
      lvl0_q  <= '0;
      lvl1_q  <= '0;
      lvl2_q  <= '0;
    end else begin
      if (accept) begin
        lock_q  <= wr_data[31];
        force_q <= wr_data[30];
        en_q    <= wr_data[29];
      end
      if (lvl_ok) begin
        lvl0_q <= wr_data[TW-1:0];
        lvl1_q <= wr_data[L1_LSB +: TW];
        lvl2_q <= wr_data[L2_LSB +: TW];
      end
    end
  end

  assign rd_data = {lock_q, force_q, en_q, lvl2_q, 1'b0, lvl1_q, 1'b0, lvl0_q};

  always_comb begin
    if (!en_q || !sense_en || temp <= lvl0_q) band = 2'd0;
    else if (temp <= lvl1_q)                  band = 2'd1;
    else if (temp <= lvl2_q)                  band = 2'd2;
    else                                      band = 2'd3;
  end

  assign forced     = force_q && (pm_state == SYNC_W'(FORCE_CODE));
  assign next_state = (forced && band < 2'd2) ? 2'd2 : band;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) throttle <= 2'd0;
    else        throttle <= next_state;
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R3
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(rd_data));

  // R7
  lvl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(lvl0_q) && $stable(lvl1_q) && $stable(lvl2_q)));

  // R4
  idle_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en_q || !sense_en) && !(force_q && pm_state == SYNC_W'(FORCE_CODE)))
      |=> throttle == 2'd0);

  // R6
  force_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && pm_state == SYNC_W'(FORCE_CODE)) |=> throttle >= 2'd2);
endmodule

// File: tb/thermal_throttle_ctrl_bench.sv
`timescale 1ns/1ps
module thermal_throttle_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [8:0]  temp = '0;
  logic        sense_en = 1'b0;
  logic [3:0]  pm_state = '0;
  logic [1:0]  throttle;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  thermal_throttle_ctrl u_thermal_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .temp(temp), .sense_en(sense_en),
    .pm_state(pm_state), .throttle(throttle)
  );

  function automatic logic [31:0] word(logic lk, logic fe, logic en,
                                       logic [8:0] a, logic [8:0] b, logic [8:0] c);
    return {lk, fe, en, c, 1'b0, b, 1'b0, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic temp_step(logic [8:0] t, logic [1:0] exp, string req);
    @(negedge clk); temp = t;
    @(posedge clk); #1;
    chk(req, 32'(throttle), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R1 word", rd_data, 32'h0);
    chk("R1 state", 32'(throttle), 32'h0);
  endtask

  task automatic t_layout;
    wr(word(0, 0, 0, 9'd100, 9'd200, 9'd300) | 32'h0008_0200);
    chk("R2 layout/reserved", rd_data, word(0, 0, 0, 9'd100, 9'd200, 9'd300));
  endtask

  task automatic t_guard;
    wr(word(0, 0, 1, 9'd1, 9'd2, 9'd3));
    chk("R7 enable with data", rd_data, word(0, 0, 1, 9'd100, 9'd200, 9'd300));
    wr(word(0, 0, 0, 9'd50, 9'd60, 9'd70));
    chk("R7 while enabled", rd_data, word(0, 0, 0, 9'd100, 9'd200, 9'd300));
    wr(word(0, 0, 1, 9'd100, 9'd200, 9'd300));
  endtask

  task automatic t_bands;
    sense_en = 1'b1;
    temp_step(9'd100, 2'd0, "R4 at first threshold");
    temp_step(9'd101, 2'd1, "R5 T1 low edge");
    temp_step(9'd200, 2'd1, "R5 T1 high edge");
    temp_step(9'd201, 2'd2, "R5 T2 low edge");
    temp_step(9'd300, 2'd2, "R5 T2 high edge");
    temp_step(9'd301, 2'd3, "R5 T3 edge");
    temp_step(9'd511, 2'd3, "R5 full scale");
    @(negedge clk); sense_en = 1'b0;
    @(posedge clk); #1; chk("R4 sensor off", 32'(throttle), 0);
    @(negedge clk); sense_en = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_latency;
    @(negedge clk); temp = 9'd250;
    #1 chk("R8 before edge", 32'(throttle), 32'd3);
    @(posedge clk); #1 chk("R8 after edge", 32'(throttle), 32'd2);
  endtask

  task automatic t_force;
    pm_state = 4'd13;
    temp_step(9'd50, 2'd0, "R6 force bit off");
    wr(word(0, 1, 1, 9'd100, 9'd200, 9'd300));
    temp_step(9'd50, 2'd2, "R6 forced to T2");
    @(negedge clk); pm_state = 4'd12;
    @(posedge clk); #1 chk("R6 other code", 32'(throttle), 0);
    @(negedge clk); pm_state = 4'd13;
    temp_step(9'd350, 2'd3, "R6 above floor");
    wr(word(0, 1, 0, 9'd100, 9'd200, 9'd300));
    temp_step(9'd350, 2'd2, "R6 forced while disabled");
    pm_state = 4'd0;
  endtask

  task automatic t_lock;
    wr(word(0, 0, 0, 9'd10, 9'd20, 9'd30));
    wr(word(1, 1, 1, 9'd10, 9'd20, 9'd30));
    chk("R9 combined write", rd_data, word(1, 1, 1, 9'd10, 9'd20, 9'd30));
    wr(32'h0);
    chk("R3 write after lock", rd_data, word(1, 1, 1, 9'd10, 9'd20, 9'd30));
    temp_step(9'd25, 2'd2, "R3 locked thresholds active");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 lock cleared by reset", rd_data, 32'h0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_layout();
    t_guard();
    t_bands();
    t_latency();
    t_force();
    t_lock();
    finish_run();
  end
endmodule